// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block divides a 32768 Hz time base down to a programmable periodic interrupt. Each cycle in which the time-base tick is high, a free-running tick counter advances. When the counter lands on an aligned multiple of the selected period, the block records a periodic event. The event sets a periodic flag and a summary interrupt flag. While the summary flag is set, the block holds a level interrupt request high.

A 4-bit rate code sets the period, and an enable bit gates the events. The flags stay set until a clear strobe arrives. In a system, that strobe comes from a read of the status register. A separate suppress input blocks the interrupt line when another timer has taken over the interrupt. Suppress does not stop the flags from being set, so software polling still works.

Top module: `periodic_irq_divider`

## Requirements
- R1: After reset, the flags and `irq_o` are low and the internal tick count is zero.
- R2: The tick count is 15 bits wide, counts every cycle with `tick_i` high, and wraps at 2^15. For rate codes 3 to 15, an event occurs on a tick whose new count is a multiple of 2^(code-1).
- R3: Rate codes 1 and 2 behave exactly as codes 8 and 9, with periods of 128 and 256 ticks.
- R4: With rate code 0, or with `pie_i` low, no tick produces an event and the flags are left unchanged. A change of code or enable takes effect at the next aligned boundary, with no extra event.
- R5: An event sets both `flag_per_o` and `flag_irq_o` at the clock edge that registers the tick. `flag_per_o` is never set while `flag_irq_o` is clear.
- R6: A one-cycle `clr_i` clears both flags at the next edge. If an event happens in the same cycle as the clear, the event wins and both flags stay set.
- R7: `irq_o` is a level output. It stays high for as long as `flag_irq_o` is set and `suppress_i` is low.
- R8: While `suppress_i` is high, `irq_o` stays low, but events still set the flags.
- R9: No event happens in a cycle without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle enable at 32768 Hz |
| rate_sel_i | input | 4 | Rate code; 0 turns periodic events off |
| pie_i | input | 1 | Periodic event enable |
| clr_i | input | 1 | Clears both flags (status read strobe) |
| suppress_i | input | 1 | Blocks the interrupt line |
| flag_irq_o | output | 1 | Summary interrupt flag |
| flag_per_o | output | 1 | Periodic event flag |
| irq_o | output | 1 | Level interrupt request |

## Verification
A vector table switches among short periods (4, 8, 32 ticks), the remapped codes 1 and 2, the longest code 15, code 0 and a disabled enable. The bench keeps the tick count running across every switch. A reference count checks each tick individually. This separates true aligned boundaries from a period that restarts on reload, from an off-by-one in the shift, and from missing remapping. Directed cases cover three things: a clear that coincides with an event, the interrupt level held over many cycles, and suppress with flags still being set.

// File: rtl/pid_pkg.sv
package pid_pkg;
   // width of the effective (remapped) rate code
   function automatic int unsigned eff_width(input int unsigned rate_w);
      return rate_w + 1;
   endfunction
   // largest effective code a rate field can produce
   function automatic int unsigned max_code(input int unsigned rate_w);
      return (1 << rate_w) - 1;
   endfunction
endpackage

// File: rtl/pid_tick_counter.sv
module pid_tick_counter #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_nxt_o
);
   logic [CNT_W-1:0] cnt_q;

   assign cnt_nxt_o = cnt_q + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_nxt_o;
   end

   // the count only moves on a tick
   assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/pid_rate_decode.sv
module pid_rate_decode
   import pid_pkg::*;
#(
   parameter int unsigned RATE_W    = 4,
   parameter int unsigned CNT_W     = 15,
   parameter bit          REMAP_LOW = 1'b1
) (
   input  logic [RATE_W-1:0] rate_i,
   input  logic              pie_i,
   output logic              en_o,
   output logic [CNT_W-1:0]  mask_o
);
   localparam int unsigned EFF_W = eff_width(RATE_W);

   logic [EFF_W-1:0] eff;

   generate
      if (REMAP_LOW) begin : g_remap
         always_comb begin
            if (rate_i == RATE_W'(1) || rate_i == RATE_W'(2))
               eff = {1'b0, rate_i} + EFF_W'(7);
            else
               eff = {1'b0, rate_i};
         end
      end else begin : g_plain
         always_comb eff = {1'b0, rate_i};
      end
   endgenerate

   assign en_o = pie_i && (rate_i != '0);

   // period is 2^(eff-1): low (eff-1) bits form the alignment mask
   for (genvar i = 0; i < CNT_W; i++) begin : g_mask
      assign mask_o[i] = (EFF_W'(i + 1) < eff);
   end
endmodule

// File: rtl/pid_status.sv
module pid_status (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic tick_i,
   input  logic en_i,
   input  logic clr_i,
   input  logic suppress_i,
   output logic flag_irq_o,
   output logic flag_per_o,
   output logic irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_irq_o <= 1'b0;
         flag_per_o <= 1'b0;
      end else if (evt_i) begin
         flag_irq_o <= 1'b1;
         flag_per_o <= 1'b1;
      end else if (clr_i) begin
         flag_irq_o <= 1'b0;
         flag_per_o <= 1'b0;
      end
   end

   assign irq_o = flag_irq_o & ~suppress_i;

   assert_evt_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> (flag_irq_o && flag_per_o));
   assert_flag_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flag_per_o |-> flag_irq_o);
   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt_i) |=> (!flag_irq_o && !flag_per_o));
   assert_no_evt_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !evt_i);
   assert_tick_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |-> tick_i);
   assert_suppress_R8: assert property (@(posedge clk) disable iff (!rst_n)
      suppress_i |-> !irq_o);
   assert_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clr_i && !suppress_i) |=> (irq_o || suppress_i));
endmodule

// File: rtl/periodic_irq_divider.sv
module periodic_irq_divider
   import pid_pkg::*;
#(
   parameter int unsigned RATE_W    = 4,
   parameter int unsigned CNT_W     = 15,
   parameter bit          REMAP_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [RATE_W-1:0] rate_sel_i,
   input  logic              pie_i,
   input  logic              clr_i,
   input  logic              suppress_i,
   output logic              flag_irq_o,
   output logic              flag_per_o,
   output logic              irq_o
);
   localparam int unsigned MIN_CNT_W = max_code(RATE_W) - 1;

   generate
      if (CNT_W < MIN_CNT_W || RATE_W < 4) begin : g_bad_cfg
         $error("periodic_irq_divider: counter too narrow for the rate field");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] mask;
   logic             en;
   logic             evt;

   pid_tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .cnt_nxt_o (cnt_nxt)
   );

   pid_rate_decode #(.RATE_W(RATE_W), .CNT_W(CNT_W), .REMAP_LOW(REMAP_LOW)) u_dec (
      .rate_i (rate_sel_i),
      .pie_i  (pie_i),
      .en_o   (en),
      .mask_o (mask)
   );

   // event on the tick whose new count sits on an aligned boundary
   assign evt = tick_i && en && ((cnt_nxt & mask) == '0);

   pid_status u_st (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt),
      .tick_i     (tick_i),
      .en_i       (en),
      .clr_i      (clr_i),
      .suppress_i (suppress_i),
      .flag_irq_o (flag_irq_o),
      .flag_per_o (flag_per_o),
      .irq_o      (irq_o)
   );
endmodule

// File: tb/test_periodic_irq_divider.sv
`timescale 1ns/1ps
module test_periodic_irq_divider;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic [3:0] rate = 4'd0;
   logic pie = 1'b0;
   logic clr = 1'b0;
   logic sup = 1'b0;
   logic f_irq, f_per, irq;

   int n_chk = 0;
   int n_fail = 0;
   logic [14:0] m_cnt = '0;
   bit done = 0;

   always #2.5 clk = ~clk;

   periodic_irq_divider i_periodic_irq_divider (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .rate_sel_i(rate), .pie_i(pie),
      .clr_i(clr), .suppress_i(sup), .flag_irq_o(f_irq), .flag_per_o(f_per), .irq_o(irq)
   );

   // {code[3:0], pie, ticks[14:0]}
   localparam int NV = 8;
   localparam logic [19:0] VEC [NV] = '{
      {4'd6,  1'b1, 15'd96},
      {4'd3,  1'b1, 15'd20},
      {4'd1,  1'b1, 15'd300},
      {4'd2,  1'b1, 15'd520},
      {4'd0,  1'b1, 15'd40},
      {4'd5,  1'b0, 15'd40},
      {4'd4,  1'b1, 15'd33},
      {4'd15, 1'b1, 15'd16400}
   };

   function automatic logic [14:0] pmask(input logic [3:0] c);
      int e;
      e = (c == 4'd1 || c == 4'd2) ? c + 7 : c;
      return 15'((1 << (e - 1)) - 1);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick_once(input logic with_clr, output logic ev);
      @(negedge clk);
      tick = 1'b1;
      clr = with_clr;
      m_cnt = m_cnt + 15'd1;
      ev = pie && (rate != 4'd0) && ((m_cnt & pmask(rate)) == '0);
      @(negedge clk);
      tick = 1'b0;
      clr = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   initial begin
      logic ev;
      string tag;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 flag_irq", f_irq, 0);
      check("R1 flag_per", f_per, 0);
      check("R1 irq", irq, 0);
      rst_n = 1'b1;
      // R9: no tick, no event, even with fast rate enabled
      rate = 4'd3; pie = 1'b1;
      repeat (10) @(negedge clk);
      check("R9 no tick", f_per, 0);

      // vector walk
      for (int v = 0; v < NV; v++) begin
         rate = VEC[v][19:16];
         pie  = VEC[v][15];
         if (rate == 4'd1 || rate == 4'd2) tag = "R3";
         else if (rate == 4'd0 || !pie) tag = "R4";
         else tag = "R2";
         for (int t = 0; t < int'(VEC[v][14:0]); t++) begin
            tick_once(1'b0, ev);
            check({tag, " per flag"}, f_per, ev);
            if (ev) begin
               check("R5 irq flag", f_irq, 1);
               pulse_clr();
               check("R6 cleared", f_per | f_irq, 0);
            end
         end
      end

      // R4: disabling keeps a set flag unchanged
      rate = 4'd3; pie = 1'b1;
      do tick_once(1'b0, ev); while (!ev);
      pie = 1'b0;
      repeat (8) tick_once(1'b0, ev);
      check("R4 flag kept", f_per, 1);
      pulse_clr();

      // R7 level held
      pie = 1'b1;
      do tick_once(1'b0, ev); while (!ev);
      repeat (20) @(negedge clk);
      check("R7 irq level", irq, 1);
      pulse_clr();
      check("R7 irq dropped", irq, 0);

      // R6: clear coincides with event, event wins
      do begin
         if (((m_cnt + 15'd1) & pmask(rate)) == '0) break;
         tick_once(1'b0, ev);
      end while (1);
      tick_once(1'b1, ev);
      check("R6 coincide", ev, 1);
      check("R6 event wins", f_per & f_irq, 1);
      pulse_clr();

      // R8 suppress
      sup = 1'b1;
      do tick_once(1'b0, ev); while (!ev);
      check("R8 flag set", f_irq, 1);
      check("R8 irq low", irq, 0);
      sup = 1'b0;
      @(negedge clk);
      check("R8 irq after release", irq, 1);
      pulse_clr();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      done = 1;
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule